// File: doc/BRIEF.md
# DMA Channel Mode and Address Engine

This block is the mode and address slice of a four-channel DMA controller. Software programs a channel's behaviour through one shared byte-wide mode port. The low bits of the byte pick the channel, and the upper six bits become that channel's stored mode. Each channel also keeps a base address and a base word count, written together through a separate port, and a working copy of each that advances as transfers complete. A single-cycle step pulse, tagged with a channel number, stands in for one finished transfer. Arbitration, request/acknowledge handshaking, upper page bits and bus cycle timing live elsewhere.

For every channel the block reports the decoded mode fields, the current address and count, whether the channel is generating addresses, and whether the memory and I/O strobes may be driven. It also reports a sticky terminal-count status and an error flag for an illegal transfer type. One channel acts as the cascade input from a second controller. It always reports cascade mode and never produces addresses or strobes. A master-clear input returns every mode register and status bit to its default without touching the address and count registers.

Top module: `dma_mode_addr_engine`

## Requirements
- R1: A mode write with `modeWrEn` high updates only the channel named by `modeWrData[1:0]`. From `modeWrData[7:2]` it stores the transfer mode (bits 7:6), the direction bit (bit 5), the autoinitialize bit (bit 4) and the transfer type (bits 3:2). The select bits are not stored, and the other channels keep their values.
- R2: `xferMode` reports each channel's mode in two bits: 00 demand, 01 single, 10 block, 11 cascade. `xferType` reports the stored type in two bits: 00 verify, 01 write (I/O to memory), 10 read (memory to I/O), 11 illegal.
- R3: When a channel accepts a step, its current address goes up by one if its direction bit is 0 and down by one if the bit is 1, wrapping modulo 2^ADDR_W. Its current count goes down by one.
- R4: If the autoinitialize bit is set and a step arrives while the current count is zero, the current address and current count are reloaded from the base registers in the next cycle.
- R5: Reset and `masterClear` set every mode register to demand, increment, autoinitialize off and verify, and clear every terminal-count status bit. `masterClear` leaves the address and count registers unchanged.
- R6: Channel 0 always reports mode 11 (cascade), whatever value is written to its mode field. Its other stored fields are still written normally.
- R7: `memStrobeEn` and `ioStrobeEn` of a channel are both high exactly when the channel is active (see R8) and its type is 01 or 10. In verify type (00) the channel still steps its address and count and still reaches terminal count, but both strobes stay low.
- R8: `addrActive` of a channel is high when the mode is not cascade and terminal-count status is clear. A step to a channel that is not active changes nothing. A cascade channel never raises a strobe or `typeErr`.
- R9: A base write loads the base address and base count and, in the same edge, the current address and current count. A step taken at count zero without autoinitialize wraps the count to all ones.
- R10: A step taken at count zero without autoinitialize sets the channel's `tcStatus`. The bit stays set, and further steps are ignored, until a base write to that channel or a master clear.
- R11: A non-cascade channel with type 11 raises `typeErr`, drives no strobes, and otherwise steps like verify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| masterClear | input | 1 | Returns modes and status to defaults |
| modeWrEn | input | 1 | Mode register write strobe |
| modeWrData | input | 8 | Mode byte: fields in 7:2, channel select in 1:0 |
| baseWrEn | input | 1 | Base address/count write strobe |
| baseWrCh | input | 2 | Channel for the base write |
| baseWrAddr | input | ADDR_W | Base address value |
| baseWrCount | input | CNT_W | Base word count value |
| stepEn | input | 1 | One transfer completed |
| stepCh | input | 2 | Channel that completed the transfer |
| xferMode | output | 8 | Two mode bits per channel, channel 0 lowest |
| xferType | output | 8 | Two type bits per channel, channel 0 lowest |
| addrDec | output | 4 | Direction bit per channel |
| autoInitEn | output | 4 | Autoinitialize bit per channel |
| addrActive | output | 4 | Channel generates addresses |
| memStrobeEn | output | 4 | Memory strobe enable per channel |
| ioStrobeEn | output | 4 | I/O strobe enable per channel |
| tcStatus | output | 4 | Sticky terminal-count status |
| typeErr | output | 4 | Illegal transfer type flag |
| curAddr | output | 4*ADDR_W | Current addresses, channel 0 lowest |
| curCount | output | 4*CNT_W | Current counts, channel 0 lowest |

## Verification
The hardest states to reach are the terminal-count boundary and the locked sticky state that follows it. Reaching them takes a mode write, a base write and then exactly count-plus-one steps to the right channel. The bench reaches them by sweeping direction, autoinitialize and each transfer type on every programmable channel with small counts. After the boundary it keeps stepping to confirm that the channel ignores further pulses or reloads. It then releases the sticky state once by master clear and once by a base write. A full sweep of all 256 mode bytes covers every select, mode, illegal type and cascade combination, including attempts to move channel 0 out of cascade.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  localparam int unsigned DMA_CH   = 4;
  localparam int unsigned CH_SEL_W = $clog2(DMA_CH);

  typedef enum logic [1:0] {
    XM_DEMAND  = 2'b00,
    XM_SINGLE  = 2'b01,
    XM_BLOCK   = 2'b10,
    XM_CASCADE = 2'b11
  } xferMode_e;

  typedef enum logic [1:0] {
    XT_VERIFY = 2'b00,
    XT_WRITE  = 2'b01,
    XT_READ   = 2'b10,
    XT_BAD    = 2'b11
  } xferType_e;

  // field order follows the stored byte bits 7:2
  typedef struct packed {
    xferMode_e mode;
    logic      dec;
    logic      autoInit;
    xferType_e xtype;
  } chanMode_t;

  localparam chanMode_t MODE_DEFAULT = '{mode: XM_DEMAND, dec: 1'b0,
                                         autoInit: 1'b0, xtype: XT_VERIFY};

  // strobes from control to datapath
  typedef struct packed {
    logic [DMA_CH-1:0] load;
    logic [DMA_CH-1:0] step;
    logic [DMA_CH-1:0] reload;
    logic [DMA_CH-1:0] dec;
  } dpCtrl_t;
endpackage

// File: rtl/dma_mode_ctrl.sv
module dma_mode_ctrl
  import dma_eng_pkg::*;
#(
  parameter int unsigned CASCADE_CH   = 0,
  parameter bit          LOCK_CASCADE = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  masterClear,
  input  logic                  modeWrEn,
  input  logic [7:0]            modeWrData,
  input  logic                  baseWrEn,
  input  logic [CH_SEL_W-1:0]   baseWrCh,
  input  logic                  stepEn,
  input  logic [CH_SEL_W-1:0]   stepCh,
  input  logic [DMA_CH-1:0]     cntZero,
  output dpCtrl_t               dpCtrl,
  output chanMode_t [DMA_CH-1:0] effMode,
  output logic [DMA_CH-1:0]     addrActive,
  output logic [DMA_CH-1:0]     memStrobeEn,
  output logic [DMA_CH-1:0]     ioStrobeEn,
  output logic [DMA_CH-1:0]     tcStatus,
  output logic [DMA_CH-1:0]     typeErr
);
  logic [CH_SEL_W-1:0] wrSel;
  chanMode_t           wrFields;
  chanMode_t           modeQ [DMA_CH];
  logic [DMA_CH-1:0]   tcQ;
  logic [DMA_CH-1:0]   loadV, stepV, reloadV, decV;

  assign wrSel    = modeWrData[CH_SEL_W-1:0];
  assign wrFields = chanMode_t'(modeWrData[7:2]);
  assign dpCtrl   = '{load: loadV, step: stepV, reload: reloadV, dec: decV};
  assign tcStatus = tcQ;

  for (genvar c = 0; c < DMA_CH; c++) begin : g_ch
    logic isCascade, movesData, tcHit;

    always_ff @(posedge clk) begin
      if (!rst_n || masterClear) begin
        modeQ[c] <= MODE_DEFAULT;
      end else if (modeWrEn && wrSel == CH_SEL_W'(c)) begin
        modeQ[c] <= wrFields;
      end
    end

    if (LOCK_CASCADE && c == CASCADE_CH) begin : g_lock
      assign effMode[c] = '{mode: XM_CASCADE, dec: modeQ[c].dec,
                            autoInit: modeQ[c].autoInit, xtype: modeQ[c].xtype};
    end else begin : g_free
      assign effMode[c] = modeQ[c];
    end

    assign isCascade      = (effMode[c].mode == XM_CASCADE);
    assign movesData      = (effMode[c].xtype == XT_WRITE) || (effMode[c].xtype == XT_READ);
    assign addrActive[c]  = !isCascade && !tcQ[c];
    assign memStrobeEn[c] = addrActive[c] && movesData;
    assign ioStrobeEn[c]  = addrActive[c] && movesData;
    assign typeErr[c]     = !isCascade && (effMode[c].xtype == XT_BAD);

    assign loadV[c]   = baseWrEn && (baseWrCh == CH_SEL_W'(c));
    assign stepV[c]   = stepEn && (stepCh == CH_SEL_W'(c)) && addrActive[c] && !loadV[c];
    assign tcHit      = stepV[c] && cntZero[c];
    assign reloadV[c] = tcHit && effMode[c].autoInit;
    assign decV[c]    = effMode[c].dec;

    always_ff @(posedge clk) begin
      if (!rst_n || masterClear || loadV[c]) begin
        tcQ[c] <= 1'b0;
      end else if (tcHit && !effMode[c].autoInit) begin
        tcQ[c] <= 1'b1;
      end
    end

    // R10: sticky status holds until a base write or master clear
    p_sticky_tc_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tcQ[c] && !loadV[c] && !masterClear) |=> tcQ[c]);

    // R7: verify type never enables a strobe
    p_verify_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (effMode[c].xtype == XT_VERIFY) |-> !(memStrobeEn[c] || ioStrobeEn[c]));

    // R11: illegal type never enables a strobe
    p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      typeErr[c] |-> !(memStrobeEn[c] || ioStrobeEn[c]));

    // R8: cascade channels never strobe, flag or step the datapath
    p_cascade_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      isCascade |-> !(memStrobeEn[c] || ioStrobeEn[c] || typeErr[c] || stepV[c]));

    // R5: master clear restores the default mode
    p_clear_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
      masterClear |=> (modeQ[c] == MODE_DEFAULT) && !tcQ[c]);
  end
endmodule

// File: rtl/dma_addr_dp.sv
module dma_addr_dp
  import dma_eng_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  dpCtrl_t                         dpCtrl,
  input  logic [ADDR_W-1:0]               baseWrAddr,
  input  logic [CNT_W-1:0]                baseWrCount,
  output logic [DMA_CH-1:0][ADDR_W-1:0]   curAddr,
  output logic [DMA_CH-1:0][CNT_W-1:0]    curCount,
  output logic [DMA_CH-1:0]               cntZero
);
  logic [ADDR_W-1:0] baseAddrQ [DMA_CH];
  logic [CNT_W-1:0]  baseCntQ  [DMA_CH];
  logic [ADDR_W-1:0] addrQ     [DMA_CH];
  logic [CNT_W-1:0]  cntQ      [DMA_CH];

  for (genvar c = 0; c < DMA_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        baseAddrQ[c] <= '0;
        baseCntQ[c]  <= '0;
        addrQ[c]     <= '0;
        cntQ[c]      <= '0;
      end else if (dpCtrl.load[c]) begin
        baseAddrQ[c] <= baseWrAddr;
        baseCntQ[c]  <= baseWrCount;
        addrQ[c]     <= baseWrAddr;
        cntQ[c]      <= baseWrCount;
      end else if (dpCtrl.reload[c]) begin
        addrQ[c] <= baseAddrQ[c];
        cntQ[c]  <= baseCntQ[c];
      end else if (dpCtrl.step[c]) begin
        addrQ[c] <= dpCtrl.dec[c] ? addrQ[c] - ADDR_W'(1) : addrQ[c] + ADDR_W'(1);
        cntQ[c]  <= cntQ[c] - CNT_W'(1);
      end
    end

    assign curAddr[c]  = addrQ[c];
    assign curCount[c] = cntQ[c];
    assign cntZero[c]  = (cntQ[c] == '0);

    // R3: accepted step moves the address one place in the chosen direction
    p_step_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dpCtrl.step[c] && !dpCtrl.reload[c] && !dpCtrl.load[c]) |=>
        (addrQ[c] == ($past(dpCtrl.dec[c]) ? $past(addrQ[c]) - ADDR_W'(1)
                                           : $past(addrQ[c]) + ADDR_W'(1))));

    // R4: reload copies the base values into the working registers
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dpCtrl.reload[c] && !dpCtrl.load[c]) |=>
        (addrQ[c] == $past(baseAddrQ[c])) && (cntQ[c] == $past(baseCntQ[c])));

    // R9: base write also loads the current registers; count wraps past zero
    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dpCtrl.load[c] |=> (addrQ[c] == $past(baseWrAddr)) && (cntQ[c] == $past(baseWrCount)));
    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dpCtrl.step[c] && !dpCtrl.reload[c] && !dpCtrl.load[c] && cntZero[c]) |=> (&cntQ[c]));

    // R8: with no strobe from control the working registers hold
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(dpCtrl.step[c] || dpCtrl.reload[c] || dpCtrl.load[c]) |=>
        $stable(addrQ[c]) && $stable(cntQ[c]));
  end
endmodule

// File: rtl/dma_mode_addr_engine.sv
module dma_mode_addr_engine
  import dma_eng_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned CASCADE_CH   = 0,
  parameter bit          LOCK_CASCADE = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      masterClear,
  input  logic                      modeWrEn,
  input  logic [7:0]                modeWrData,
  input  logic                      baseWrEn,
  input  logic [CH_SEL_W-1:0]       baseWrCh,
  input  logic [ADDR_W-1:0]         baseWrAddr,
  input  logic [CNT_W-1:0]          baseWrCount,
  input  logic                      stepEn,
  input  logic [CH_SEL_W-1:0]       stepCh,
  output logic [2*DMA_CH-1:0]       xferMode,
  output logic [2*DMA_CH-1:0]       xferType,
  output logic [DMA_CH-1:0]         addrDec,
  output logic [DMA_CH-1:0]         autoInitEn,
  output logic [DMA_CH-1:0]         addrActive,
  output logic [DMA_CH-1:0]         memStrobeEn,
  output logic [DMA_CH-1:0]         ioStrobeEn,
  output logic [DMA_CH-1:0]         tcStatus,
  output logic [DMA_CH-1:0]         typeErr,
  output logic [DMA_CH*ADDR_W-1:0]  curAddr,
  output logic [DMA_CH*CNT_W-1:0]   curCount
);
  dpCtrl_t                        dpCtrl;
  chanMode_t [DMA_CH-1:0]         effMode;
  logic [DMA_CH-1:0][ADDR_W-1:0]  dpAddr;
  logic [DMA_CH-1:0][CNT_W-1:0]   dpCount;
  logic [DMA_CH-1:0]              cntZero;

  dma_mode_ctrl #(.CASCADE_CH(CASCADE_CH), .LOCK_CASCADE(LOCK_CASCADE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .masterClear(masterClear),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .baseWrEn(baseWrEn), .baseWrCh(baseWrCh),
    .stepEn(stepEn), .stepCh(stepCh), .cntZero(cntZero),
    .dpCtrl(dpCtrl), .effMode(effMode), .addrActive(addrActive),
    .memStrobeEn(memStrobeEn), .ioStrobeEn(ioStrobeEn),
    .tcStatus(tcStatus), .typeErr(typeErr)
  );

  dma_addr_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .dpCtrl(dpCtrl),
    .baseWrAddr(baseWrAddr), .baseWrCount(baseWrCount),
    .curAddr(dpAddr), .curCount(dpCount), .cntZero(cntZero)
  );

  for (genvar c = 0; c < DMA_CH; c++) begin : g_out
    assign xferMode[2*c +: 2] = effMode[c].mode;
    assign xferType[2*c +: 2] = effMode[c].xtype;
    assign addrDec[c]         = effMode[c].dec;
    assign autoInitEn[c]      = effMode[c].autoInit;
  end

  assign curAddr  = dpAddr;
  assign curCount = dpCount;
endmodule

// File: tb/sim_dma_mode_addr_engine.sv
module sim_dma_mode_addr_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int CW = 4;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic masterClear = 1'b0, modeWrEn = 1'b0, baseWrEn = 1'b0, stepEn = 1'b0;
  logic [7:0] modeWrData = '0;
  logic [1:0] baseWrCh = '0, stepCh = '0;
  logic [AW-1:0] baseWrAddr = '0;
  logic [CW-1:0] baseWrCount = '0;
  logic [2*NCH-1:0] xferMode, xferType;
  logic [NCH-1:0] addrDec, autoInitEn, addrActive, memStrobeEn, ioStrobeEn, tcStatus, typeErr;
  logic [NCH*AW-1:0] curAddr;
  logic [NCH*CW-1:0] curCount;

  int checks = 0;
  int errors = 0;

  logic [5:0]    mMode [NCH];
  logic [AW-1:0] mBase [NCH], mAddr [NCH];
  logic [CW-1:0] mBaseCnt [NCH], mCnt [NCH];
  logic          mTc [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_mode_addr_engine #(.ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .masterClear(masterClear),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .baseWrEn(baseWrEn), .baseWrCh(baseWrCh), .baseWrAddr(baseWrAddr),
    .baseWrCount(baseWrCount), .stepEn(stepEn), .stepCh(stepCh),
    .xferMode(xferMode), .xferType(xferType), .addrDec(addrDec),
    .autoInitEn(autoInitEn), .addrActive(addrActive),
    .memStrobeEn(memStrobeEn), .ioStrobeEn(ioStrobeEn),
    .tcStatus(tcStatus), .typeErr(typeErr),
    .curAddr(curAddr), .curCount(curCount)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] expMode(input int c);
    return (c == 0) ? 2'b11 : mMode[c][5:4];
  endfunction

  task automatic checkAll();
    for (int c = 0; c < NCH; c++) begin
      logic casc, act, mv;
      casc = (expMode(c) == 2'b11);
      act  = !casc && !mTc[c];
      mv   = (mMode[c][1:0] == 2'b01) || (mMode[c][1:0] == 2'b10);
      chk("R2/R6 mode", xferMode[2*c +: 2], expMode(c));
      chk("R1/R2 type", xferType[2*c +: 2], mMode[c][1:0]);
      chk("R1/R3 dir", addrDec[c], mMode[c][3]);
      chk("R1/R4 autoinit", autoInitEn[c], mMode[c][2]);
      chk("R8 active", addrActive[c], act);
      chk("R7 mem strobe", memStrobeEn[c], act && mv);
      chk("R7 io strobe", ioStrobeEn[c], act && mv);
      chk("R10 tc", tcStatus[c], mTc[c]);
      chk("R11 err", typeErr[c], !casc && mMode[c][1:0] == 2'b11);
      chk("R3/R4/R9 addr", curAddr[c*AW +: AW], mAddr[c]);
      chk("R3/R4/R9 count", curCount[c*CW +: CW], mCnt[c]);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    modeWrEn = 1'b0; baseWrEn = 1'b0; stepEn = 1'b0; masterClear = 1'b0;
    @(negedge clk);
  endtask

  task automatic writeMode(input logic [7:0] d);
    modeWrEn = 1'b1; modeWrData = d;
    mMode[d[1:0]] = d[7:2];
    tick();
  endtask

  task automatic writeBase(input int c, input logic [AW-1:0] a, input logic [CW-1:0] n);
    baseWrEn = 1'b1; baseWrCh = 2'(c); baseWrAddr = a; baseWrCount = n;
    mBase[c] = a; mAddr[c] = a; mBaseCnt[c] = n; mCnt[c] = n; mTc[c] = 1'b0;
    tick();
  endtask

  task automatic doClear();
    masterClear = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      mMode[c] = 6'b000000; mTc[c] = 1'b0;
    end
    tick();
  endtask

  task automatic doStep(input int c);
    stepEn = 1'b1; stepCh = 2'(c);
    if (expMode(c) != 2'b11 && !mTc[c]) begin
      if (mCnt[c] == '0 && mMode[c][2]) begin
        mAddr[c] = mBase[c]; mCnt[c] = mBaseCnt[c];
      end else begin
        if (mCnt[c] == '0) mTc[c] = 1'b1;
        mAddr[c] = mMode[c][3] ? mAddr[c] - 1'b1 : mAddr[c] + 1'b1;
        mCnt[c]  = mCnt[c] - 1'b1;
      end
    end
    tick();
    checkAll();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      mMode[c] = '0; mBase[c] = '0; mAddr[c] = '0;
      mBaseCnt[c] = '0; mCnt[c] = '0; mTc[c] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset defaults, R6 channel 0 cascade
    checkAll();

    // R1 R2 R6 R11: every mode byte
    for (int d = 0; d < 256; d++) begin
      writeMode(8'(d));
      checkAll();
    end

    // R5: master clear restores defaults, keeps addresses
    writeBase(2, 8'h44, 4'd5);
    writeMode(8'b10_1_1_01_01);
    writeMode(8'b01_0_1_11_11);
    doClear();
    checkAll();

    // R3 R4 R7 R9 R10 R11: stepping sweep through terminal count
    for (int c = 1; c < NCH; c++)
      for (int dir = 0; dir < 2; dir++)
        for (int ai = 0; ai < 2; ai++)
          for (int ty = 0; ty < 4; ty++) begin
            writeMode({2'(c % 3), 1'(dir), 1'(ai), 2'(ty), 2'(c)});
            writeBase(c, dir ? 8'h01 : 8'hFE, 4'(c));
            checkAll();
            for (int s = 0; s < c + 4; s++) doStep(c);
          end

    // R10: sticky state released by master clear, then by base write
    writeMode(8'b00_0_0_01_01);
    writeBase(1, 8'h10, 4'd0);
    doStep(1);
    doStep(1);
    doClear();
    checkAll();
    doStep(1);
    writeMode(8'b00_1_0_10_01);
    writeBase(1, 8'h20, 4'd0);
    doStep(1);
    doStep(1);
    writeBase(1, 8'h30, 4'd2);
    checkAll();
    doStep(1);

    // R8: cascade channels ignore steps
    writeMode(8'b00_0_0_01_00);
    writeBase(0, 8'h55, 4'd3);
    doStep(0);
    doStep(0);
    writeMode(8'b11_0_0_10_10);
    writeBase(2, 8'h66, 4'd3);
    doStep(2);
    doStep(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule